// File: doc/BRIEF.md
# Sixteen-Bit Serial Result Shifter

This block is the device-side output stage of a 12-bit sampling converter. A host supplies a serial clock and reads one 16-bit frame per conversion on a single data line. Each frame is four zero bits followed by the 12-bit result, most significant bit first, in straight binary. After the sixteenth falling edge of the serial clock the data line is released through a separate output-enable. The conversion core copies each new result into an output register with a load strobe. The convert-start input re-synchronises the shifter so that every conversion cycle begins in a known state.

All inputs are sampled on the block's system clock. Each edge of the serial clock or of convert-start takes effect on the first system clock edge that sees the new level. The outputs change on that same system clock edge.

Top module: `result_serializer`

## Requirements
- R1: While reset is held and directly after it, `sdataOe` is 0 and `sdataOut` is 0. `sdataOut` is 0 whenever `sdataOe` is 0.
- R2: A rising serial clock edge seen with the bit counter at zero loads the frame and asserts `sdataOe`. `sdataOut` then shows the first leading zero.
- R3: The frame is {4'b0000, result[11:0]}. After the k-th falling edge (k = 1..15), `sdataOut` shows frame bit 15-k. A rising edge inside a frame leaves the shown bit unchanged.
- R4: The sixteenth falling edge deasserts `sdataOe`.
- R5: A rising edge after the sixteenth falling edge starts the frame again from the first leading zero. The line then stays enabled while the serial clock is stopped.
- R6: A falling edge of `convStartN` seen while `sclkIn` is 0 clears the bit counter and deasserts `sdataOe`. The next read returns a whole frame from its first bit.
- R7: A falling edge of `convStartN` seen while `sclkIn` is 1 has no effect on a frame in progress.
- R8: The serial clock may pause low at any point in a frame. The shown bit and the enable hold during the pause, and the frame resumes where it stopped.
- R9: `resultLoad` copies `resultIn` into the output register. A frame that has already started keeps the value captured at its first rising edge. The next frame carries the new value.
- R10: The 12 result bits are straight binary: bit i of the frame's data field equals bit i of the loaded value, for all-zero, all-one, alternating and every single-bit pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host |
| convStartN | input | 1 | Convert-start, active falling edge |
| resultIn | input | 12 | Conversion result from the core |
| resultLoad | input | 1 | End-of-conversion strobe that copies resultIn |
| sdataOut | output | 1 | Serial data bit |
| sdataOe | output | 1 | Drive enable for the data line |

## Verification
The frame is read back for all-zero, all-one, the two alternating patterns and each of the twelve one-hot values. A single-bit value exposes any misplaced or swapped bit position, and the alternating patterns expose a shift that is off by one. Other runs separate the control cases from one another: a read continued past sixteen edges, a read aborted by convert-start while the clock is low, a convert-start falling while the clock is high, a read split into two bytes, and a result reload in the middle of a frame. Each of these leaves a different trace of enable and data on the pins.

// File: rtl/serial_shifter_pkg.sv
package serial_shifter_pkg;
  typedef struct packed {
    logic clear;
    logic loadFrame;
    logic shift;
  } shiftStrobes_t;
endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import serial_shifter_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkIn,
  input  logic          convStartN,
  output shiftStrobes_t strobes,
  output logic          oe
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             sclkD, convD;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkRise, sclkFall, convFall, clearHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      convD <= 1'b1;
    end else begin
      sclkD <= sclkIn;
      convD <= convStartN;
    end
  end

  always_comb begin
    sclkRise = sclkIn & ~sclkD;
    sclkFall = ~sclkIn & sclkD;
    convFall = ~convStartN & convD;
    clearHit = convFall & ~sclkIn;
    strobes.clear     = clearHit;
    strobes.loadFrame = sclkRise & (bitCnt == '0) & ~clearHit;
    strobes.shift     = sclkFall & ~clearHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      oe     <= 1'b0;
    end else if (strobes.clear) begin
      bitCnt <= '0;
      oe     <= 1'b0;
    end else if (strobes.loadFrame) begin
      oe <= 1'b1;
    end else if (strobes.shift) begin
      if (bitCnt == LAST) begin
        bitCnt <= '0;
        oe     <= 1'b0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shifter_datapath.sv
module shifter_datapath
  import serial_shifter_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              resultLoad,
  input  shiftStrobes_t     strobes,
  output logic              bitNow
);
  localparam int FRAME_W = DATA_W + LEAD_W;

  logic [DATA_W-1:0]  outReg;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (resultLoad) outReg <= resultIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.clear) shiftReg <= '0;
    else if (strobes.loadFrame) shiftReg <= {{LEAD_W{1'b0}}, outReg};
    else if (strobes.shift) shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
  end

  assign bitNow = shiftReg[FRAME_W-1];
endmodule

// File: rtl/result_serializer.sv
module result_serializer
  import serial_shifter_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              convStartN,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              resultLoad,
  output logic              sdataOut,
  output logic              sdataOe
);
  localparam int FRAME_W = DATA_W + LEAD_W;

  shiftStrobes_t strobes;
  logic          oe, bitNow;

  shifter_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .convStartN(convStartN),
    .strobes(strobes), .oe(oe)
  );

  shifter_datapath #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .resultIn(resultIn), .resultLoad(resultLoad),
    .strobes(strobes), .bitNow(bitNow)
  );

  assign sdataOe  = oe;
  assign sdataOut = oe & bitNow;
endmodule

// File: rtl/result_serializer_checker.sv
module result_serializer_checker (
  input logic clk,
  input logic rstN,
  input logic sclkIn,
  input logic convStartN,
  input logic sdataOut,
  input logic sdataOe
);
  // R1: the enable is low on the first edge after reset is released
  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rstN) |-> !sdataOe);

  // R1: a disabled line never carries a one
  p_off_is_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !sdataOe |-> !sdataOut);

  // R2: every frame begins with a leading zero
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> !sdataOut);

  // R4/R6: the line is released only when the serial clock was seen low
  p_release_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdataOe) |-> !$past(sclkIn));

  // R8: with both control inputs still, the outputs hold
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclkIn) == $past(sclkIn, 2)) && ($past(convStartN) == $past(convStartN, 2))
    |-> $stable(sdataOut) && $stable(sdataOe));
endmodule

bind result_serializer result_serializer_checker u_chk (
  .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .convStartN(convStartN),
  .sdataOut(sdataOut), .sdataOe(sdataOe)
);

// File: tb/result_serializer_bench.sv
module result_serializer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b0;
  logic        convStartN = 1'b1;
  logic [11:0] resultIn = '0;
  logic        resultLoad = 1'b0;
  logic        sdataOut, sdataOe;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  result_serializer u_result_serializer (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .convStartN(convStartN),
    .resultIn(resultIn), .resultLoad(resultLoad),
    .sdataOut(sdataOut), .sdataOe(sdataOe)
  );

  function automatic logic frameBit(input logic [11:0] v, input int idx);
    logic [15:0] f;
    f = {4'b0000, v};
    return f[15 - idx];
  endfunction

  task automatic check(input string req, input logic expOe, input logic expBit);
    nChecks++;
    if (sdataOe !== expOe || sdataOut !== expBit) begin
      nFails++;
      $display("FAIL %s: oe=%b data=%b expected oe=%b data=%b at %0t",
               req, sdataOe, sdataOut, expOe, expBit, $time);
    end
  endtask

  task automatic loadResult(input logic [11:0] v);
    resultIn = v; resultLoad = 1'b1;
    @(negedge clk);
    resultLoad = 1'b0;
    @(negedge clk);
  endtask

  task automatic convPulse(input string req);
    convStartN = 1'b0;
    @(negedge clk);
    convStartN = 1'b1;
    @(negedge clk);
    if (sclkIn == 1'b0) check(req, 1'b0, 1'b0);
  endtask

  task automatic riseAt(input logic [11:0] v, input int k, input string req);
    sclkIn = 1'b1;
    @(negedge clk);
    check(req, 1'b1, frameBit(v, k));
  endtask

  task automatic fallTo(input logic [11:0] v, input int k, input string req);
    sclkIn = 1'b0;
    @(negedge clk);
    if (k < 16) check(req, 1'b1, frameBit(v, k));
    else check(req, 1'b0, 1'b0);
  endtask

  task automatic fullFrame(input logic [11:0] v, input string req);
    riseAt(v, 0, "R2");
    for (int k = 1; k <= 16; k++) begin
      fallTo(v, k, (k == 16) ? "R4" : req);
      if (k < 16) riseAt(v, k, "R3");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    // R10 / R3: sweep of distinct patterns
    begin
      logic [11:0] pats [4];
      pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'hAAA; pats[3] = 12'h555;
      for (int p = 0; p < 4; p++) begin
        loadResult(pats[p]);
        convPulse("R6");
        fullFrame(pats[p], "R10");
      end
    end
    for (int b = 0; b < 12; b++) begin
      loadResult(12'(1) << b);
      convPulse("R6");
      fullFrame(12'(1) << b, "R10");
    end

    // R5: clocks past sixteen restart the frame and keep the line driven
    loadResult(12'hC35);
    convPulse("R6");
    fullFrame(12'hC35, "R3");
    riseAt(12'hC35, 0, "R5");
    repeat (10) @(negedge clk);
    check("R5", 1'b1, 1'b0);
    for (int k = 1; k <= 16; k++) begin
      fallTo(12'hC35, k, "R5");
      if (k < 16) riseAt(12'hC35, k, "R5");
    end

    // R6: abort mid-frame with the serial clock low
    loadResult(12'h9E1);
    convPulse("R6");
    riseAt(12'h9E1, 0, "R2");
    for (int k = 1; k <= 6; k++) begin
      fallTo(12'h9E1, k, "R6");
      riseAt(12'h9E1, k, "R6");
    end
    fallTo(12'h9E1, 7, "R6");
    convPulse("R6");
    fullFrame(12'h9E1, "R6");

    // R7: convert-start falls while the serial clock is high
    loadResult(12'h3C7);
    convPulse("R6");
    riseAt(12'h3C7, 0, "R2");
    convStartN = 1'b0;
    @(negedge clk);
    check("R7", 1'b1, frameBit(12'h3C7, 0));
    for (int k = 1; k <= 16; k++) begin
      fallTo(12'h3C7, k, "R7");
      if (k == 3) convStartN = 1'b1;
      if (k < 16) riseAt(12'h3C7, k, "R7");
    end

    // R8: two-byte read with a pause in between
    loadResult(12'h6B2);
    convPulse("R6");
    riseAt(12'h6B2, 0, "R2");
    for (int k = 1; k <= 16; k++) begin
      fallTo(12'h6B2, k, "R8");
      if (k == 8) begin
        repeat (20) @(negedge clk);
        check("R8", 1'b1, frameBit(12'h6B2, 8));
      end
      if (k < 16) riseAt(12'h6B2, k, "R8");
    end

    // R9: a reload mid-frame leaves the running frame alone
    loadResult(12'h5A3);
    convPulse("R6");
    riseAt(12'h5A3, 0, "R2");
    for (int k = 1; k <= 16; k++) begin
      fallTo(12'h5A3, k, "R9");
      if (k == 5) begin
        loadResult(12'hA5C);
        check("R9", 1'b1, frameBit(12'h5A3, 5));
      end
      if (k < 16) riseAt(12'h5A3, k, "R9");
    end
    convPulse("R6");
    fullFrame(12'hA5C, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule